// File: doc/BRIEF.md
# Flash Programming Mode Controller

This block is a behavioural model of the parallel programming port of an on-chip flash code store. An external programmer holds the device in programming mode and then selects one operation with four mode strobes, an active-low chip enable, an active-low output enable and a three-level supply indication. The operations are read, output disable, program, program verify, erase-all, erase verify and inhibit. Read data is returned on a separate output bus with its own drive enable, so a pad ring can build the bidirectional bus around it.

The byte array is small and parameterised. Address 0xFFFF does not reach the array. It selects an 8-bit security register whose bits can only be cleared by programming. Only erase-all sets them back to 1. Program and erase act once, on the first clock edge of each entry into the operation. Because of this, a programmer may hold a command for many cycles without repeating it.

Top module: `flash_prog_ctrl`

## Requirements
- R1: The block acts only while `pm_rst` is 1, `pm_ale` is 0 and `pm_psen_n` is 1. In any other case no operation is decoded, storage does not change and `dout_en` is 0.
- R2: Read-class operations set `dout_en` to 1 and put the addressed byte on `dout`. These are read (strobes 4'b0000, `ce_n`=0, `oe_n`=0, `supply`=0 normal), program verify (strobes 4'b0000, `ce_n`=1, `oe_n`=0, `supply`=1 program) and erase verify (strobes 4'b0001, `ce_n`=1, `oe_n`=0, `supply`=2 erase). Address 0xFFFF returns the security register. Any other address uses its low log2(DEPTH) bits as the array index.
- R3: Output disable (strobes 4'b0000, `ce_n`=0, `oe_n`=1, supply normal) drives `dout_en` to 0 and `dout` to 0x00.
- R4: Program (strobes 4'b0000, `ce_n`=0, `oe_n`=1, supply program) writes `din` to the addressed byte. The write happens only on the first rising clock edge of each entry into program. If `din` changes while program is held, the stored byte does not change.
- R5: Erase-all (strobe bit 0 = 1, bits 3:1 = 0, `ce_n`=0, `oe_n`=1, supply erase, `addr[0]`=0, `din`=0xFF) sets every array byte and all security bits to 0xFF on its first edge. If the address bit or the data does not match, the cycle does nothing.
- R6: When `ce_n`=1 and `oe_n`=1 with the supply at program or erase level, nothing is written or erased and `dout_en` is 0, whatever the strobes, address and data are.
- R7: Programming address 0xFFFF stores the bitwise AND of the old security value and `din`. A security bit therefore never goes from 0 to 1 except through erase-all.
- R8: Every other combination of strobes, enables and supply (including supply code 3) is a no-operation. `dout_en` is 0 and storage is unchanged.
- R9: After `rst_n` is released, every array byte and the security register read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; program and erase take effect on its rising edge |
| rst_n | input | 1 | Active-low reset of the model, sets storage to the erased state |
| pm_rst | input | 1 | Programming-mode qualifier, must be 1 |
| pm_ale | input | 1 | Programming-mode qualifier, must be 0 |
| pm_psen_n | input | 1 | Programming-mode qualifier, must be 1 |
| mode_ctl | input | 4 | Mode strobes; bit 0 selects the erase family |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| supply | input | 2 | Supply level: 0 normal, 1 program, 2 erase, 3 reserved |
| addr | input | 16 | Byte address; 0xFFFF selects the security register |
| din | input | 8 | Program / erase data in |
| dout | output | 8 | Read data, 0x00 when not driven |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
If the security register is wrong, for example a bit that has come back to 1, the wrong value is visible at `dout` on the next read of 0xFFFF. Program verify or erase verify shows it in the same way, one cycle after the write edge. If the entry detector is broken, a byte that was overwritten by a later `din` value appears. This shows up at the first read after a held program command. A wrong operation decode appears at once as a wrong `dout_en` in the cycle of the command, with no clock edge needed.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    OP_NOP, OP_READ, OP_ODIS, OP_PROG, OP_PVER, OP_ERASE, OP_EVER, OP_INH
  } fpm_op_e;

  localparam logic [1:0] SUP_NORM  = 2'd0;
  localparam logic [1:0] SUP_PROG  = 2'd1;
  localparam logic [1:0] SUP_ERASE = 2'd2;
  localparam logic [15:0] SEC_ADDR = 16'hFFFF;

  function automatic fpm_op_e fpm_decode_f(
    input logic       qual,
    input logic [3:0] ctl,
    input logic       ce_n,
    input logic       oe_n,
    input logic [1:0] sup,
    input logic       a0,
    input logic [7:0] din
  );
    fpm_op_e op;
    logic hv;
    op = OP_NOP;
    hv = (sup == SUP_PROG) || (sup == SUP_ERASE);
    if (qual && ctl[3:1] == 3'b000) begin
      if (ce_n && oe_n && hv) begin
        op = OP_INH;
      end else if (!ctl[0]) begin
        unique case ({ce_n, oe_n, sup})
          {2'b00, SUP_NORM}: op = OP_READ;
          {2'b01, SUP_NORM}: op = OP_ODIS;
          {2'b01, SUP_PROG}: op = OP_PROG;
          {2'b10, SUP_PROG}: op = OP_PVER;
          default:           op = OP_NOP;
        endcase
      end else if (sup == SUP_ERASE) begin
        if (!ce_n && oe_n && !a0 && din == 8'hFF) op = OP_ERASE;
        else if (ce_n && !oe_n)                   op = OP_EVER;
      end
    end
    return op;
  endfunction

  function automatic logic [7:0] sec_merge_f(input logic [7:0] old, input logic [7:0] nw);
    return old & nw;
  endfunction

endpackage

// File: rtl/fpm_decode.sv
module fpm_decode
  import fpm_pkg::*;
(
  input  logic       pm_rst,
  input  logic       pm_ale,
  input  logic       pm_psen_n,
  input  logic [3:0] mode_ctl,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic [1:0] supply,
  input  logic       addr0,
  input  logic [7:0] din,
  output fpm_op_e    op,
  output logic       qualified
);
  assign qualified = pm_rst && !pm_ale && pm_psen_n;
  assign op = fpm_decode_f(qualified, mode_ctl, ce_n, oe_n, supply, addr0, din);
endmodule

// File: rtl/fpm_store.sv
module fpm_store
  import fpm_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fpm_op_e       op,
  input  logic [15:0]   addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_byte,
  output logic [DW-1:0] sec_q,
  output logic          wr_pulse,
  output logic          er_pulse
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  fpm_op_e       op_prev;
  logic          is_sec;
  logic [AW-1:0] idx;

  assign is_sec   = (addr == SEC_ADDR);
  assign idx      = addr[AW-1:0];
  assign wr_pulse = (op == OP_PROG)  && (op_prev != OP_PROG);
  assign er_pulse = (op == OP_ERASE) && (op_prev != OP_ERASE);
  assign rd_byte  = is_sec ? sec_q : mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) op_prev <= OP_NOP;
    else        op_prev <= op;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '1;
    end else if (er_pulse) begin
      sec_q <= '1;
    end else if (wr_pulse && is_sec) begin
      sec_q <= sec_merge_f(sec_q, din);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n || er_pulse) begin
        mem[g] <= '1;
      end else if (wr_pulse && !is_sec && idx == AW'(g)) begin
        mem[g] <= din;
      end
    end
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpm_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pm_rst,
  input  logic        pm_ale,
  input  logic        pm_psen_n,
  input  logic [3:0]  mode_ctl,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic [1:0]  supply,
  input  logic [15:0] addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_en
);
  fpm_op_e    op;
  logic       qualified;
  logic [7:0] rd_byte;
  logic [7:0] sec_q;
  logic       wr_pulse;
  logic       er_pulse;

  fpm_decode u_dec (
    .pm_rst(pm_rst), .pm_ale(pm_ale), .pm_psen_n(pm_psen_n),
    .mode_ctl(mode_ctl), .ce_n(ce_n), .oe_n(oe_n), .supply(supply),
    .addr0(addr[0]), .din(din), .op(op), .qualified(qualified)
  );

  fpm_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .din(din),
    .rd_byte(rd_byte), .sec_q(sec_q), .wr_pulse(wr_pulse), .er_pulse(er_pulse)
  );

  assign dout_en = (op == OP_READ) || (op == OP_PVER) || (op == OP_EVER);
  assign dout    = dout_en ? rd_byte : 8'h00;
endmodule

// File: rtl/fpm_chk.sv
module fpm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       qualified,
  input logic       ce_n,
  input logic       oe_n,
  input logic [1:0] supply,
  input logic       dout_en,
  input logic       wr_pulse,
  input logic       er_pulse,
  input logic [7:0] sec_q
);
  // R1
  unqual_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qualified |-> (!dout_en && !wr_pulse && !er_pulse));

  // R2
  drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !oe_n);

  // R4
  prog_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R5
  erase_sets_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_pulse |=> (sec_q == 8'hFF));

  // R6
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && oe_n && (supply == 2'd1 || supply == 2'd2)) |-> (!wr_pulse && !er_pulse && !dout_en));

  // R7
  sec_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !er_pulse |=> ((sec_q & ~$past(sec_q)) == 8'h00));
endmodule

bind flash_prog_ctrl fpm_chk i_fpm_chk (
  .clk(clk), .rst_n(rst_n), .qualified(qualified), .ce_n(ce_n), .oe_n(oe_n),
  .supply(supply), .dout_en(dout_en), .wr_pulse(wr_pulse), .er_pulse(er_pulse),
  .sec_q(sec_q)
);

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pm_rst = 1'b1, pm_ale = 1'b0, pm_psen_n = 1'b1;
  logic [3:0] mode_ctl = 4'h0;
  logic ce_n = 1'b0, oe_n = 1'b0;
  logic [1:0] supply = 2'd0;
  logic [15:0] addr = 16'h0;
  logic [7:0] din = 8'h0;
  logic [7:0] dout;
  logic dout_en;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  flash_prog_ctrl i_flash_prog_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {ctl, ce_n, oe_n, supply, addr, din, exp_en, exp_dout}
  localparam logic [40:0] VEC [NV] = '{
    {4'h0,1'b0,1'b0,2'd0,16'h0010,8'h00,1'b1,8'hFF}, // R2 read erased
    {4'h0,1'b0,1'b1,2'd1,16'h0010,8'h5A,1'b0,8'h00}, // R4 program
    {4'h0,1'b1,1'b0,2'd1,16'h0010,8'h00,1'b1,8'h5A}, // R2 program verify
    {4'h0,1'b0,1'b1,2'd0,16'h0010,8'h00,1'b0,8'h00}, // R3 output disable
    {4'h0,1'b0,1'b0,2'd0,16'h0010,8'h00,1'b1,8'h5A}, // R2 read
    {4'h0,1'b0,1'b1,2'd1,16'hFFFF,8'hF0,1'b0,8'h00}, // R7 program sec
    {4'h0,1'b0,1'b0,2'd0,16'hFFFF,8'h00,1'b1,8'hF0}, // R7
    {4'h0,1'b0,1'b1,2'd1,16'hFFFF,8'h3C,1'b0,8'h00}, // R7
    {4'h0,1'b0,1'b0,2'd0,16'hFFFF,8'h00,1'b1,8'h30}, // R7 AND
    {4'h0,1'b0,1'b1,2'd1,16'hFFFF,8'hFF,1'b0,8'h00}, // R7 try set
    {4'h0,1'b0,1'b0,2'd0,16'hFFFF,8'h00,1'b1,8'h30}, // R7 sticky
    {4'h1,1'b1,1'b1,2'd2,16'h0010,8'hFF,1'b0,8'h00}, // R6 inhibit
    {4'h0,1'b0,1'b0,2'd0,16'h0010,8'h00,1'b1,8'h5A}, // R6 unchanged
    {4'h1,1'b0,1'b1,2'd2,16'h0001,8'hFF,1'b0,8'h00}, // R5 bad a0
    {4'h0,1'b0,1'b0,2'd0,16'h0010,8'h00,1'b1,8'h5A}, // R5 no erase
    {4'h1,1'b0,1'b1,2'd2,16'h0000,8'h00,1'b0,8'h00}, // R5 bad data
    {4'h0,1'b0,1'b0,2'd0,16'h0010,8'h00,1'b1,8'h5A}, // R5 no erase
    {4'h0,1'b0,1'b0,2'd3,16'h0010,8'h00,1'b0,8'h00}, // R8 reserved supply
    {4'h2,1'b0,1'b1,2'd1,16'h0020,8'h11,1'b0,8'h00}, // R8 other strobe
    {4'h0,1'b0,1'b0,2'd0,16'h0020,8'h00,1'b1,8'hFF}, // R8 unchanged
    {4'h1,1'b0,1'b1,2'd2,16'h0000,8'hFF,1'b0,8'h00}, // R5 erase-all
    {4'h1,1'b1,1'b0,2'd2,16'h0010,8'h00,1'b1,8'hFF}, // R5 erase verify
    {4'h1,1'b1,1'b0,2'd2,16'hFFFF,8'h00,1'b1,8'hFF}, // R5 sec restored
    {4'h0,1'b0,1'b1,2'd1,16'h0030,8'h77,1'b0,8'h00}, // R4 program
    {4'h0,1'b0,1'b0,2'd0,16'h0030,8'h00,1'b1,8'h77}  // R2 read back
  };

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got en=%0b dout=%02h expected en=%0b dout=%02h",
               req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic ce, input logic oe,
                       input logic [1:0] s, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    mode_ctl = c; ce_n = ce; oe_n = oe; supply = s; addr = a; din = d;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    apply(4'h0, 1'b0, 1'b0, 2'd0, 16'h0000, 8'h00);
    check("R9 array", {dout_en, dout}, 9'h1FF);
    apply(4'h0, 1'b0, 1'b0, 2'd0, 16'hFFFF, 8'h00);
    check("R9 sec", {dout_en, dout}, 9'h1FF);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][40:37], VEC[i][36], VEC[i][35], VEC[i][34:33], VEC[i][32:17], VEC[i][16:9]);
      check($sformatf("vec %0d R2-class", i), {dout_en, dout}, VEC[i][8:0]);
    end

    // R4 held program: din changes while held
    apply(4'h0, 1'b0, 1'b1, 2'd1, 16'h0040, 8'h12);
    apply(4'h0, 1'b0, 1'b1, 2'd1, 16'h0040, 8'h34);
    apply(4'h0, 1'b0, 1'b1, 2'd1, 16'h0040, 8'h56);
    apply(4'h0, 1'b0, 1'b0, 2'd0, 16'h0040, 8'h00);
    check("R4 once per entry", {dout_en, dout}, 9'h112);

    // R1 qualifiers
    pm_ale = 1'b1;
    apply(4'h0, 1'b0, 1'b0, 2'd0, 16'h0040, 8'h00);
    check("R1 ale read", {dout_en, dout}, 9'h000);
    apply(4'h0, 1'b0, 1'b1, 2'd1, 16'h0050, 8'h99);
    pm_ale = 1'b0; pm_rst = 1'b0;
    apply(4'h0, 1'b0, 1'b1, 2'd1, 16'h0050, 8'h98);
    pm_rst = 1'b1; pm_psen_n = 1'b0;
    apply(4'h1, 1'b0, 1'b1, 2'd2, 16'h0000, 8'hFF);
    pm_psen_n = 1'b1;
    apply(4'h0, 1'b0, 1'b0, 2'd0, 16'h0050, 8'h00);
    check("R1 no program", {dout_en, dout}, 9'h1FF);
    apply(4'h0, 1'b0, 1'b0, 2'd0, 16'h0040, 8'h00);
    check("R1 no erase", {dout_en, dout}, 9'h112);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule